// File: doc/BRIEF.md
# Counted Block Copy Engine

This block is a small sequencer that moves a run of bytes from one memory region to another. It works on a single-port synchronous memory and performs one byte at a time. Software or a controlling state machine first loads a source address, a destination address and a transfer count. It then pulses a start strobe, with a mode input that says whether the count is 8 or 16 bits wide. From that point the engine owns the memory bus until it reports completion. The final register contents are always visible on its outputs.

For each byte, the engine reads the source, writes the byte to the destination, and then advances both addresses and decrements the count. A count that is zero when the operation starts skips every memory access. The run time is fixed at 8 + 4n cycles, where n is the effective count. That overhead is 4 setup cycles, then 4 cycles per byte (2 for the read, 2 for the write), then 4 finish cycles. The engine has no flag outputs and no other side effects.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, busy, done and mem_we are 0, and src_out, dst_out and cnt_out are all 0.
- R2: A load_en pulse while idle copies load_src, load_dst and load_cnt into src_out, dst_out and cnt_out from the next cycle on. A load_en pulse while busy is ignored.
- R3: A start pulse while busy is ignored. It neither restarts nor lengthens the operation, and busy is 0 after the single done pulse.
- R4: For each byte, the byte at the source address is read with one cycle of read latency and written unchanged to the destination address. After the run, memory holds exactly what a sequential ascending byte copy produces, including when the two regions overlap.
- R5: After each byte, the source and destination addresses each increase by 1, wrapping modulo 2^16. Final values are the start values plus n.
- R6: After each byte the effective count decreases by 1. The run stops when it reaches zero, so the effective part of cnt_out ends at 0.
- R7: With word_mode=0 at start, the effective count is cnt[7:0] (up to 255) and cnt[15:8] keeps its initial value. With word_mode=1, the effective count is all 16 bits (up to 65535).
- R8: If the effective count is 0 at start, no write is made, the addresses and count are unchanged, and the operation completes in 8 cycles.
- R9: busy is high for exactly 8 + 4n consecutive cycles, starting the cycle after start is accepted. done is high for one cycle, which is the last busy cycle.
- R10: mem_we is never high while idle. Exactly n writes occur, at addresses dst, dst+1, and so on in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| word_mode | input | 1 | Count width at start: 0 = low 8 bits, 1 = full 16 bits |
| load_en | input | 1 | Load the three registers (taken only when idle) |
| load_src | input | 16 | Source address to load |
| load_dst | input | 16 | Destination address to load |
| load_cnt | input | 16 | Count to load |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Current source address register |
| dst_out | output | 16 | Current destination address register |
| cnt_out | output | 16 | Current count register |

## Verification
A wrong phase counter shows within one byte period. Writes land on the wrong cycle, at a source address, or with stale data, and any corrupted byte then shows up in the memory image compared after the run. A stale mode latch or a bad zero test changes the busy length or the number of writes, so it is visible no later than the done pulse. Errors in the address or count registers show on src_out, dst_out and cnt_out as soon as the run ends, and the write-address monitor catches address errors on the first bad write.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_FIN   = 2'd3
  } bc_state_e;
endpackage

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
  import blkcopy_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int FIN_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cnt_zero,
  input  logic cnt_last,
  output logic busy,
  output logic done,
  output logic accept,
  output logic cap_en,
  output logic wr_en,
  output logic step_en,
  output logic use_dst
);
  localparam int PHASES = 4;
  localparam int TMAX_A = (SETUP_CYC > FIN_CYC) ? SETUP_CYC : FIN_CYC;
  localparam int TMAX   = (TMAX_A > PHASES) ? TMAX_A : PHASES;
  localparam int TMR_W  = $clog2(TMAX);
  localparam logic [TMR_W-1:0] SETUP_END = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] FIN_END   = TMR_W'(FIN_CYC - 1);
  localparam logic [TMR_W-1:0] PH_CAP    = TMR_W'(1);
  localparam logic [TMR_W-1:0] PH_WR     = TMR_W'(2);
  localparam logic [TMR_W-1:0] PH_STEP   = TMR_W'(PHASES - 1);

  bc_state_e        state;
  logic [TMR_W-1:0] tmr;

  assign accept  = (state == ST_IDLE) && start;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN) && (tmr == FIN_END);
  assign cap_en  = (state == ST_XFER) && (tmr == PH_CAP);
  assign wr_en   = (state == ST_XFER) && (tmr == PH_WR);
  assign step_en = (state == ST_XFER) && (tmr == PH_STEP);
  assign use_dst = (state == ST_XFER) && (tmr >= PH_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tmr   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tmr <= '0;
          if (start) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (tmr == SETUP_END) begin
            tmr   <= '0;
            state <= cnt_zero ? ST_FIN : ST_XFER;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_XFER: begin
          if (tmr == PH_STEP) begin
            tmr <= '0;
            if (cnt_last) state <= ST_FIN;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_FIN: begin
          if (tmr == FIN_END) begin
            tmr   <= '0;
            state <= ST_IDLE;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              accept,
  input  logic              word_mode,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              cap_en,
  input  logic              step_en,
  input  logic              use_dst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              word_q,
  output logic              cnt_zero,
  output logic              cnt_last
);
  localparam int LO_W = CNT_W / 2;
  localparam int HI_W = CNT_W - LO_W;

  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c, input logic wide);
    return wide ? c : {{HI_W{1'b0}}, c[LO_W-1:0]};
  endfunction

  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] c, input logic wide);
    return wide ? (c - CNT_W'(1)) : {c[CNT_W-1:LO_W], c[LO_W-1:0] - LO_W'(1)};
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_eff;
  logic             load_ok;

  assign cnt_eff  = eff_count(cnt_q, word_q);
  assign cnt_zero = (cnt_eff == '0);
  assign cnt_last = (cnt_eff == CNT_W'(1));
  assign load_ok  = load_en && !busy;
  assign mem_addr = use_dst ? dst_q : src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      word_q <= 1'b0;
    end else begin
      if (load_ok) begin
        src_q <= load_src;
        dst_q <= load_dst;
        cnt_q <= load_cnt;
      end else if (step_en) begin
        src_q <= next_addr(src_q);
        dst_q <= next_addr(dst_q);
        cnt_q <= dec_count(cnt_q, word_q);
      end
      if (accept) word_q <= word_mode;
      if (cap_en) data_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int SETUP_CYC = 4,
  parameter int FIN_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              word_mode,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [CNT_W-1:0]  cnt_out
);
  logic accept, cap_en, wr_en, step_en, use_dst;
  logic cnt_zero, cnt_last, word_q;
  logic [DATA_W-1:0] data_q;

  blkcopy_seq #(
    .SETUP_CYC(SETUP_CYC),
    .FIN_CYC  (FIN_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cnt_zero(cnt_zero),
    .cnt_last(cnt_last),
    .busy    (busy),
    .done    (done),
    .accept  (accept),
    .cap_en  (cap_en),
    .wr_en   (wr_en),
    .step_en (step_en),
    .use_dst (use_dst)
  );

  blkcopy_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .accept   (accept),
    .word_mode(word_mode),
    .load_en  (load_en),
    .load_src (load_src),
    .load_dst (load_dst),
    .load_cnt (load_cnt),
    .cap_en   (cap_en),
    .step_en  (step_en),
    .use_dst  (use_dst),
    .mem_rdata(mem_rdata),
    .src_q    (src_out),
    .dst_q    (dst_out),
    .cnt_q    (cnt_out),
    .data_q   (data_q),
    .mem_addr (mem_addr),
    .word_q   (word_q),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last)
  );

  assign mem_wdata = data_q;
  assign mem_we    = wr_en;
endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] src_out,
  input logic [ADDR_W-1:0] dst_out,
  input logic [CNT_W-1:0]  cnt_out,
  input logic              step_en,
  input logic              word_q
);
  localparam int LO_W = CNT_W / 2;

  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  assert_write_to_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == dst_out);

  assert_wdata_from_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == $past(mem_rdata));

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_done_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_src_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> src_out == $past(src_out) + ADDR_W'(1));

  assert_dst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> dst_out == $past(dst_out) + ADDR_W'(1));

  assert_word_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && word_q) |=> cnt_out == $past(cnt_out) - CNT_W'(1));

  assert_hi_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_q) |=> cnt_out[CNT_W-1:LO_W] == $past(cnt_out[CNT_W-1:LO_W]));
endmodule

bind blkcopy_engine blkcopy_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata),
  .src_out  (src_out),
  .dst_out  (dst_out),
  .cnt_out  (cnt_out),
  .step_en  (step_en),
  .word_q   (word_q)
);

// File: tb/sim_blkcopy_engine.sv
`timescale 1ns/1ps
module sim_blkcopy_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, word_mode, load_en;
  logic [15:0] load_src, load_dst, load_cnt;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_we, busy, done;
  logic [15:0] src_out, dst_out, cnt_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [7:0] mem  [256];
  logic [7:0] expm [256];

  always #10 clk = ~clk;

  blkcopy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
    .load_en(load_en), .load_src(load_src), .load_dst(load_dst), .load_cnt(load_cnt),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                        input bit wide, input bit inject, input int seed);
    int n, cycles, dones, done_at, writes, bad_addr, mism;
    logic [15:0] es, ed, ec;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 13 + seed * 29 + 5);
      expm[i] = mem[i];
    end
    n = wide ? int'(c) : int'(c[7:0]);
    for (int k = 0; k < n; k++) expm[8'(d + 16'(k))] = expm[8'(s + 16'(k))];
    es = s + 16'(n);
    ed = d + 16'(n);
    ec = wide ? 16'h0000 : {c[15:8], 8'h00};

    @(negedge clk);
    load_en = 1'b1; load_src = s; load_dst = d; load_cnt = c;
    @(negedge clk);
    load_en = 1'b0;
    chk(src_out == s, "R2", "loaded src", src_out, s);
    chk(dst_out == d, "R2", "loaded dst", dst_out, d);
    chk(cnt_out == c, "R2", "loaded cnt", cnt_out, c);
    start = 1'b1; word_mode = wide;
    @(negedge clk);
    start = 1'b0;

    cycles = 0; dones = 0; done_at = -1; writes = 0; bad_addr = 0;
    while (busy && cycles < 70000) begin
      cycles++;
      if (done) begin dones++; done_at = cycles; end
      if (mem_we) begin
        if (mem_addr != d + 16'(writes)) bad_addr++;
        writes++;
      end
      if (inject && cycles == 6) begin
        start = 1'b1; load_en = 1'b1;
        load_src = 16'h1357; load_dst = 16'h2468; load_cnt = 16'h0033;
      end else begin
        start = 1'b0; load_en = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; load_en = 1'b0;

    chk(cycles == 8 + 4 * n, "R9", "busy length", cycles, 8 + 4 * n);
    chk(dones == 1, "R9", "done pulses", dones, 1);
    chk(done_at == cycles, "R9", "done in last busy cycle", done_at, cycles);
    if (n == 0) chk(writes == 0, "R8", "writes on zero count", writes, 0);
    else        chk(writes == n, "R10", "write count", writes, n);
    chk(bad_addr == 0, "R10", "out-of-order write addresses", bad_addr, 0);
    chk(src_out == es, "R5", "final src", src_out, es);
    chk(dst_out == ed, "R5", "final dst", dst_out, ed);
    if (wide) chk(cnt_out == ec, "R6", "final word count", cnt_out, ec);
    else      chk(cnt_out == ec, "R7", "final byte count, upper kept", cnt_out, ec);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) mism++;
    chk(mism == 0, "R4", "memory image mismatches", mism, 0);
    if (inject) begin
      @(negedge clk);
      chk(!busy, "R3", "busy after done despite start", busy, 0);
      chk(src_out == es, "R2", "load while busy ignored", src_out, es);
    end
  endtask

  initial begin
    int ns [6] = '{1, 2, 3, 5, 17, 255};
    rst_n = 1'b0; start = 1'b0; word_mode = 1'b0; load_en = 1'b0;
    load_src = '0; load_dst = '0; load_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!done, "R1", "done after reset", done, 0);
    chk(!mem_we, "R1", "mem_we after reset", mem_we, 0);
    chk(src_out == 0 && dst_out == 0 && cnt_out == 0, "R1", "registers after reset",
        {src_out, dst_out, cnt_out}, 0);

    // R8: zero effective count, byte mode with upper byte set, and word mode
    run_op(16'h0010, 16'h0080, 16'hA500, 1'b0, 1'b0, 1);
    run_op(16'h0100, 16'h0230, 16'h0000, 1'b1, 1'b0, 2);
    // R7: byte mode sweep, upper count byte kept
    for (int i = 0; i < 6; i++)
      run_op(16'h0020, 16'h0090, {8'h5A, 8'(ns[i])}, 1'b0, 1'b0, 10 + i);
    // R6/R7: word mode counts, including above 255
    run_op(16'h0300, 16'h0410, 16'h0007, 1'b1, 1'b0, 3);
    run_op(16'h0000, 16'h0080, 16'h012C, 1'b1, 1'b0, 4);
    run_op(16'h0005, 16'h0085, 16'h0100, 1'b1, 1'b0, 5);
    // R5: address wrap past 0xFFFF
    run_op(16'hFFFE, 16'h3010, 16'h0004, 1'b1, 1'b0, 6);
    run_op(16'h7000, 16'hFFFD, 16'h0006, 1'b0, 1'b0, 7);
    // R4: overlapping regions copied in ascending order
    run_op(16'h0040, 16'h0041, 16'h0005, 1'b0, 1'b0, 8);
    // R3/R2: start and load while busy ignored
    run_op(16'h0050, 16'h00C0, 16'h0009, 1'b1, 1'b1, 9);
    run_op(16'h0060, 16'h00D0, 16'hFF03, 1'b0, 1'b1, 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule